// File: doc/BRIEF.md
# Programmable Clock-Enable Divider Tree

This block turns one fast clock into eight clock-enable strobes for the processor, local bus, peripheral bus, external bus, memory access layer, PCI and two UART domains. The fast clock stands for the PLL output, or for the reference when the PLL is bypassed. Every domain is an integer down-counter that emits a one-cycle strobe each time it wraps. The counters form a cascade. The local bus counts processor strobes. The peripheral, external, memory-access and PCI domains count local-bus strobes. The processor domain and both UARTs count every fast cycle.

A 32-bit register bus (address, write data, enable and write flag, with read data decoded combinationally from the address) holds two PLL mode words, a UART divisor word, a control word, a reset-reason word, a PCI word, a read-only boot status word and a read-only ID word. From the reference frequency, the feedback multiplier and the forward divider, the block works out whether the PLL path is selected and whether the VCO frequency falls outside its legal window. It reports the latter as a configuration-error flag. There is no streaming data path, so every pin is a plain control or status signal without a handshake.

Top module: `clk_div_tree`

## Requirements
- R1: After reset the registers read as follows: mode word 0 at 0x0F0 reads 0x00021002, mode word 1 at 0x0F4 reads 0x80A552BE, the UART word at 0x0F5 reads 0x00004646, boot status at 0x0F1 reads 0x00000011, reset reason at 0x0F6 reads 0x00040000, ID at 0x0F7 reads 0x20267049, and control at 0x0F3 and PCI at 0x0F9 both read 0.
- R2: A write stores data ANDed with a per-register mask: 0x00633333 for mode 0, 0xC0F73FFF for mode 1, 0x003F7F7F for the UART word and 0xC00000F3 for control. Reset reason and PCI store all 32 bits. Writes to boot status and ID have no effect. Unmapped addresses (for example 0x0F2 and 0x0F8) read 0.
- R3: `pll_sel` is 1 exactly when bit 31 of mode word 1 is 1 and bit 30 is 0.
- R4: Bit 0 of the boot status word becomes 1 one cycle after `pll_sel` is 1. It becomes 0 one cycle after mode-1 bit 30 is 1. Otherwise it holds its value. Bit 4 always reads 1.
- R5: `cfg_err` is 1 exactly when `pll_sel` is 1 and REF_MHZ × M × D lies outside [VCO_MIN_MHZ, VCO_MAX_MHZ], both limits inclusive. M is mode-1 bits 23:20, with 0 meaning 16. D is 8 minus mode-1 bits 18:16.
- R6: `clk_en[0]` (processor) strobes once every (mode-0 bits 21:20 + 1) fast cycles. `clk_en[1]` (local bus) strobes once every (mode-0 bits 17:16 + 1) processor strobes, and always in the same cycle as one of them.
- R7: These domains count local-bus strobes and each strobe coincides with a local-bus strobe: `clk_en[2]` (peripheral) divides by bits 13:12 + 1, `clk_en[3]` (external) by bits 9:8 + 2, `clk_en[4]` (memory access) by bits 5:4 + 1, and `clk_en[5]` (PCI) by bits 1:0 + 1.
- R8: `clk_en[6]` and `clk_en[7]` (UART 0 and 1) strobe once every N fast cycles. N is UART-word bits 6:0 and 14:8 respectively, with 0 meaning 128.
- R9: In the cycle after any write to 0x0F0, 0x0F4 or 0x0F5, and in the first cycle after reset, no strobe is asserted and every counter restarts. Each domain then strobes on the N-th parent strobe that follows. Writes to any other address leave the counters undisturbed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock (PLL output or bypassed reference) |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_en | input | 1 | Register access strobe |
| reg_we | input | 1 | Write flag for the access |
| reg_addr | input | ADDR_W | Register number |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| pll_sel | output | 1 | PLL path selected |
| cfg_err | output | 1 | VCO frequency out of range while the PLL path is selected |
| clk_en | output | 8 | Domain strobes: 0 processor, 1 local bus, 2 peripheral, 3 external, 4 memory access, 5 PCI, 6 UART 0, 7 UART 1 |

## Verification
The bench builds the block with REF_MHZ = 25, a 500 to 1000 MHz window and 8-bit counters. With a 25 MHz reference, both window limits are reached exactly (M × D of 20 and 40), so the inclusive edges are tested alongside clear violations on either side. It also tests the case where a multiplier field of 0 must be read as 16 to stay legal. Eight-bit counters hold the 128 ratio of a zero UART field, so the widest divisor is exercised in a few hundred cycles.

// File: rtl/cdt_pkg.sv
package cdt_pkg;
  localparam int unsigned DOM_N = 8;
  localparam int unsigned RAT_W = 8;

  localparam int DOM_CPU   = 0;
  localparam int DOM_LBUS  = 1;
  localparam int DOM_PBUS  = 2;
  localparam int DOM_EBUS  = 3;
  localparam int DOM_MAL   = 4;
  localparam int DOM_PCI   = 5;
  localparam int DOM_UART0 = 6;
  localparam int DOM_UART1 = 7;

  localparam int unsigned ADR_MODE0 = 32'h0F0;
  localparam int unsigned ADR_BOOT  = 32'h0F1;
  localparam int unsigned ADR_CTL   = 32'h0F3;
  localparam int unsigned ADR_MODE1 = 32'h0F4;
  localparam int unsigned ADR_UCR   = 32'h0F5;
  localparam int unsigned ADR_RSN   = 32'h0F6;
  localparam int unsigned ADR_ID    = 32'h0F7;
  localparam int unsigned ADR_PCI   = 32'h0F9;

  localparam logic [31:0] MSK_MODE0 = 32'h0063_3333;
  localparam logic [31:0] MSK_MODE1 = 32'hC0F7_3FFF;
  localparam logic [31:0] MSK_UCR   = 32'h003F_7F7F;
  localparam logic [31:0] MSK_CTL   = 32'hC000_00F3;

  localparam logic [31:0] RST_MODE0 = 32'h0002_1002;
  localparam logic [31:0] RST_MODE1 = 32'h80A5_52BE;
  localparam logic [31:0] RST_UCR   = 32'h0000_4646;
  localparam logic [31:0] RST_BOOT  = 32'h0000_0010;
  localparam logic [31:0] RST_RSN   = 32'h0004_0000;
  localparam logic [31:0] ID_WORD   = 32'h2026_7049;

  // Parent domain of each divider; -1 means the fast clock itself.
  function automatic int parent_of(input int d);
    case (d)
      DOM_LBUS:                             return DOM_CPU;
      DOM_PBUS, DOM_EBUS, DOM_MAL, DOM_PCI: return DOM_LBUS;
      default:                              return -1;
    endcase
  endfunction

  // Division ratio of a domain, decoded from the configuration words.
  function automatic logic [RAT_W-1:0] ratio_of(input int d, input logic [31:0] m0,
                                                 input logic [31:0] ucr);
    case (d)
      DOM_CPU:   return RAT_W'(m0[21:20]) + RAT_W'(1);
      DOM_LBUS:  return RAT_W'(m0[17:16]) + RAT_W'(1);
      DOM_PBUS:  return RAT_W'(m0[13:12]) + RAT_W'(1);
      DOM_EBUS:  return RAT_W'(m0[9:8]) + RAT_W'(2);
      DOM_MAL:   return RAT_W'(m0[5:4]) + RAT_W'(1);
      DOM_PCI:   return RAT_W'(m0[1:0]) + RAT_W'(1);
      DOM_UART0: return (ucr[6:0] == 7'd0) ? RAT_W'(128) : RAT_W'(ucr[6:0]);
      default:   return (ucr[14:8] == 7'd0) ? RAT_W'(128) : RAT_W'(ucr[14:8]);
    endcase
  endfunction
endpackage

// File: rtl/cdt_div.sv
module cdt_div #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         reload,
  input  logic         tick_in,
  input  logic [W-1:0] ratio,
  output logic         tick_out
);
  logic [W-1:0] cnt_q;
  logic         at_zero;

  assign at_zero  = (cnt_q == '0);
  assign tick_out = tick_in & ~reload & at_zero;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (reload)  cnt_q <= ratio - W'(1);
    else if (tick_in) cnt_q <= at_zero ? ratio - W'(1) : cnt_q - W'(1);
  end
endmodule

// File: rtl/cdt_pll_chk.sv
module cdt_pll_chk #(
  parameter int unsigned REF_MHZ     = 25,
  parameter int unsigned VCO_MIN_MHZ = 500,
  parameter int unsigned VCO_MAX_MHZ = 1000
) (
  input  logic [31:0] mode1,
  output logic        pll_sel,
  output logic        cfg_err
);
  logic [4:0]  mult;
  logic [3:0]  fwd;
  logic [31:0] vco;

  always_comb begin
    pll_sel = mode1[31] & ~mode1[30];
    mult    = (mode1[23:20] == 4'd0) ? 5'd16 : {1'b0, mode1[23:20]};
    fwd     = 4'd8 - {1'b0, mode1[18:16]};
    vco     = REF_MHZ * 32'(mult) * 32'(fwd);
    cfg_err = pll_sel && ((vco < VCO_MIN_MHZ) || (vco > VCO_MAX_MHZ));
  end
endmodule

// File: rtl/cdt_regs.sv
module cdt_regs import cdt_pkg::*; #(
  parameter int unsigned ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_en,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  input  logic              pll_sel,
  output logic [31:0]       reg_rdata,
  output logic [31:0]       mode0,
  output logic [31:0]       mode1,
  output logic [31:0]       ucr,
  output logic              div_cfg_wr
);
  localparam logic [ADDR_W-1:0] AW_MODE0 = ADDR_W'(ADR_MODE0);
  localparam logic [ADDR_W-1:0] AW_BOOT  = ADDR_W'(ADR_BOOT);
  localparam logic [ADDR_W-1:0] AW_CTL   = ADDR_W'(ADR_CTL);
  localparam logic [ADDR_W-1:0] AW_MODE1 = ADDR_W'(ADR_MODE1);
  localparam logic [ADDR_W-1:0] AW_UCR   = ADDR_W'(ADR_UCR);
  localparam logic [ADDR_W-1:0] AW_RSN   = ADDR_W'(ADR_RSN);
  localparam logic [ADDR_W-1:0] AW_ID    = ADDR_W'(ADR_ID);
  localparam logic [ADDR_W-1:0] AW_PCI   = ADDR_W'(ADR_PCI);

  logic [31:0] ctl_q, rsn_q, pci_q;
  logic        lock_q;
  logic        wr;

  assign wr         = reg_en & reg_we;
  assign div_cfg_wr = wr && (reg_addr == AW_MODE0 || reg_addr == AW_MODE1 ||
                             reg_addr == AW_UCR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode0 <= RST_MODE0;
      mode1 <= RST_MODE1;
      ucr   <= RST_UCR;
      ctl_q <= '0;
      rsn_q <= RST_RSN;
      pci_q <= '0;
    end else if (wr) begin
      case (reg_addr)
        AW_MODE0: mode0 <= reg_wdata & MSK_MODE0;
        AW_MODE1: mode1 <= reg_wdata & MSK_MODE1;
        AW_UCR:   ucr   <= reg_wdata & MSK_UCR;
        AW_CTL:   ctl_q <= reg_wdata & MSK_CTL;
        AW_RSN:   rsn_q <= reg_wdata;
        AW_PCI:   pci_q <= reg_wdata;
        default:  ;
      endcase
    end
  end

  // Lock indication: set while the PLL path is used, cleared by the bypass bit.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        lock_q <= 1'b1;
    else if (pll_sel)  lock_q <= 1'b1;
    else if (mode1[30]) lock_q <= 1'b0;
  end

  always_comb begin
    case (reg_addr)
      AW_MODE0: reg_rdata = mode0;
      AW_BOOT:  reg_rdata = RST_BOOT | {31'd0, lock_q};
      AW_CTL:   reg_rdata = ctl_q;
      AW_MODE1: reg_rdata = mode1;
      AW_UCR:   reg_rdata = ucr;
      AW_RSN:   reg_rdata = rsn_q;
      AW_ID:    reg_rdata = ID_WORD;
      AW_PCI:   reg_rdata = pci_q;
      default:  reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/clk_div_tree.sv
module clk_div_tree import cdt_pkg::*; #(
  parameter int unsigned ADDR_W      = 10,
  parameter int unsigned REF_MHZ     = 25,
  parameter int unsigned VCO_MIN_MHZ = 500,
  parameter int unsigned VCO_MAX_MHZ = 1000,
  parameter int unsigned CNT_W       = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_en,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              pll_sel,
  output logic              cfg_err,
  output logic [DOM_N-1:0]  clk_en
);
  logic [31:0] mode0, mode1, ucr;
  logic        div_cfg_wr;
  logic        reload_q;

  cdt_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_en     (reg_en),
    .reg_we     (reg_we),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .pll_sel    (pll_sel),
    .reg_rdata  (reg_rdata),
    .mode0      (mode0),
    .mode1      (mode1),
    .ucr        (ucr),
    .div_cfg_wr (div_cfg_wr)
  );

  cdt_pll_chk #(
    .REF_MHZ     (REF_MHZ),
    .VCO_MIN_MHZ (VCO_MIN_MHZ),
    .VCO_MAX_MHZ (VCO_MAX_MHZ)
  ) u_pll (
    .mode1   (mode1),
    .pll_sel (pll_sel),
    .cfg_err (cfg_err)
  );

  // One restart cycle after reset and after every divider reconfiguration.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) reload_q <= 1'b1;
    else        reload_q <= div_cfg_wr;
  end

  for (genvar d = 0; d < DOM_N; d++) begin : g_dom
    localparam int PAR = parent_of(d);
    logic             par_tick;
    logic [CNT_W-1:0] ratio;

    if (PAR < 0) begin : g_root
      assign par_tick = 1'b1;
    end else begin : g_leaf
      assign par_tick = clk_en[PAR];
    end

    assign ratio = CNT_W'(ratio_of(d, mode0, ucr));

    cdt_div #(.W(CNT_W)) u_div (
      .clk      (clk),
      .rst_n    (rst_n),
      .reload   (reload_q),
      .tick_in  (par_tick),
      .ratio    (ratio),
      .tick_out (clk_en[d])
    );
  end
endmodule

// File: rtl/cdt_chk.sv
module cdt_chk import cdt_pkg::*; #(
  parameter int unsigned ADDR_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_en,
  input logic              reg_we,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [31:0]       reg_wdata,
  input logic [DOM_N-1:0]  clk_en,
  input logic              pll_sel,
  input logic              cfg_err,
  input logic              reload_q
);
  logic cfg_hit;
  assign cfg_hit = reg_en && reg_we &&
                   (reg_addr == ADDR_W'(ADR_MODE0) || reg_addr == ADDR_W'(ADR_MODE1) ||
                    reg_addr == ADDR_W'(ADR_UCR));

  // R9: a divider reconfiguration write is followed by a restart cycle
  a_r9_restart_follows: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_hit |=> reload_q);

  // R9: nothing strobes during the restart cycle
  a_r9_quiet_restart: assert property (@(posedge clk) disable iff (!rst_n)
    reload_q |-> (clk_en == '0));

  // R6: local-bus strobe sits on a processor strobe
  a_r6_lbus_nested: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en[DOM_LBUS] |-> clk_en[DOM_CPU]);

  // R7: downstream domains strobe only with the local bus
  a_r7_child_nested: assert property (@(posedge clk) disable iff (!rst_n)
    (|clk_en[DOM_PCI:DOM_PBUS]) |-> clk_en[DOM_LBUS]);

  // R5: error flag only on the PLL path
  a_r5_err_needs_pll: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> pll_sel);

  // R3: selection follows the written mode-1 control bits
  a_r3_sel_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_en && reg_we && reg_addr == ADDR_W'(ADR_MODE1)) |=>
      (pll_sel == ($past(reg_wdata[31]) && !$past(reg_wdata[30]))));
endmodule

bind clk_div_tree cdt_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_en    (reg_en),
  .reg_we    (reg_we),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .clk_en    (clk_en),
  .pll_sel   (pll_sel),
  .cfg_err   (cfg_err),
  .reload_q  (reload_q)
);

// File: tb/clk_div_tree_tb.sv
`timescale 1ns/1ps
module clk_div_tree_tb;
  localparam int REF = 25;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_en = 1'b0;
  logic        reg_we = 1'b0;
  logic [9:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        pll_sel, cfg_err;
  logic [7:0]  clk_en;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  clk_div_tree #(
    .ADDR_W(10), .REF_MHZ(REF), .VCO_MIN_MHZ(500), .VCO_MAX_MHZ(1000), .CNT_W(8)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .pll_sel(pll_sel), .cfg_err(cfg_err), .clk_en(clk_en)
  );

  // Behavioural reference: mirrored configuration and parent-tick tallies.
  logic [31:0] m_mode0 = 32'h0002_1002;
  logic [31:0] m_mode1 = 32'h80A5_52BE;
  logic [31:0] m_ucr   = 32'h0000_4646;
  bit          m_rl    = 1'b1;
  int          acc [8];
  int          par_tab [8] = '{-1, 0, 1, 1, 1, 1, -1, -1};

  function automatic int ratio_exp(int d);
    case (d)
      0: return int'(m_mode0[21:20]) + 1;
      1: return int'(m_mode0[17:16]) + 1;
      2: return int'(m_mode0[13:12]) + 1;
      3: return int'(m_mode0[9:8]) + 2;
      4: return int'(m_mode0[5:4]) + 1;
      5: return int'(m_mode0[1:0]) + 1;
      6: return (m_ucr[6:0] == 0) ? 128 : int'(m_ucr[6:0]);
      default: return (m_ucr[14:8] == 0) ? 128 : int'(m_ucr[14:8]);
    endcase
  endfunction

  function automatic bit pll_exp();
    return m_mode1[31] && !m_mode1[30];
  endfunction

  function automatic bit err_exp();
    int m;
    int f;
    int v;
    m = (m_mode1[23:20] == 0) ? 16 : int'(m_mode1[23:20]);
    f = 8 - int'(m_mode1[18:16]);
    v = REF * m * f;
    return pll_exp() && (v < 500 || v > 1000);
  endfunction

  function automatic logic [7:0] strobes();
    logic [7:0] e;
    e = '0;
    for (int d = 0; d < 8; d++) begin
      bit p;
      p = (par_tab[d] < 0) ? 1'b1 : e[par_tab[d]];
      e[d] = p && !m_rl && (acc[d] == ratio_exp(d) - 1);
    end
    return e;
  endfunction

  function automatic string tag_of(logic [7:0] diff);
    if (m_rl)                       return "R9";
    if (diff[1:0] != 0)             return "R6";
    if (diff[5:2] != 0)             return "R7";
    return "R8";
  endfunction

  always @(posedge clk) begin
    bit          c_rst, c_wr;
    logic [9:0]  c_a;
    logic [31:0] c_d;
    logic [7:0]  e;
    c_rst = rst_n;
    c_wr  = reg_en && reg_we;
    c_a   = reg_addr;
    c_d   = reg_wdata;
    #1;
    if (!c_rst) begin
      m_mode0 = 32'h0002_1002;
      m_mode1 = 32'h80A5_52BE;
      m_ucr   = 32'h0000_4646;
      m_rl    = 1'b1;
      for (int d = 0; d < 8; d++) acc[d] = 0;
    end else begin
      e = strobes();
      for (int d = 0; d < 8; d++) begin
        bit p;
        p = (par_tab[d] < 0) ? 1'b1 : e[par_tab[d]];
        if (m_rl)   acc[d] = 0;
        else if (p) acc[d] = e[d] ? 0 : acc[d] + 1;
      end
      m_rl = c_wr && (c_a == 10'h0F0 || c_a == 10'h0F4 || c_a == 10'h0F5);
      if (c_wr) begin
        if (c_a == 10'h0F0) m_mode0 = c_d & 32'h0063_3333;
        if (c_a == 10'h0F4) m_mode1 = c_d & 32'hC0F7_3FFF;
        if (c_a == 10'h0F5) m_ucr   = c_d & 32'h003F_7F7F;
      end
      e = strobes();
      checks++;
      if (clk_en !== e) begin
        errors++;
        $display("FAIL %s strobes actual %b expected %b", tag_of(clk_en ^ e), clk_en, e);
      end
      checks++;
      if (pll_sel !== pll_exp()) begin
        errors++;
        $display("FAIL R3 pll_sel actual %b expected %b", pll_sel, pll_exp());
      end
      checks++;
      if (cfg_err !== err_exp()) begin
        errors++;
        $display("FAIL R5 cfg_err actual %b expected %b", cfg_err, err_exp());
      end
    end
  end

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_en = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_en = 1'b0; reg_we = 1'b0;
  endtask

  task automatic rd(input logic [9:0] a, input logic [31:0] exp, input string tag);
    repeat (2) @(negedge clk);
    reg_addr = a;
    #1;
    checks++;
    if (reg_rdata !== exp) begin
      errors++;
      $display("FAIL %s read 0x%03h actual 0x%08h expected 0x%08h", tag, a, reg_rdata, exp);
    end
  endtask

  task automatic flag(input logic act, input logic exp, input string tag);
    @(negedge clk);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s flag actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset contents
    rd(10'h0F0, 32'h0002_1002, "R1");
    rd(10'h0F4, 32'h80A5_52BE, "R1");
    rd(10'h0F5, 32'h0000_4646, "R1");
    rd(10'h0F1, 32'h0000_0011, "R1");
    rd(10'h0F6, 32'h0004_0000, "R1");
    rd(10'h0F7, 32'h2026_7049, "R1");
    rd(10'h0F3, 32'h0000_0000, "R1");
    rd(10'h0F9, 32'h0000_0000, "R1");
    run(200);
    // R2 masks, read-only words, unmapped holes; control write must not restart (R9)
    wr(10'h0F3, 32'hFFFF_FFFF); rd(10'h0F3, 32'hC000_00F3, "R2");
    wr(10'h0F6, 32'h1234_5678); rd(10'h0F6, 32'h1234_5678, "R2");
    wr(10'h0F9, 32'hA5A5_A5A5); rd(10'h0F9, 32'hA5A5_A5A5, "R2");
    wr(10'h0F1, 32'h0000_0000); rd(10'h0F1, 32'h0000_0011, "R2");
    wr(10'h0F7, 32'h0000_0000); rd(10'h0F7, 32'h2026_7049, "R2");
    rd(10'h0F2, 32'h0, "R2"); rd(10'h0F8, 32'h0, "R2"); rd(10'h100, 32'h0, "R2");
    wr(10'h0F5, 32'hFFFF_FFFF); rd(10'h0F5, 32'h003F_7F7F, "R2");
    wr(10'h0F0, 32'hFFFF_FFFF); rd(10'h0F0, 32'h0063_3333, "R2");
    run(300);
    wr(10'h0F4, 32'hFFFF_FFFF); rd(10'h0F4, 32'hC0F7_3FFF, "R2");
    flag(pll_sel, 1'b0, "R3");
    rd(10'h0F1, 32'h0000_0010, "R4");
    // R5 window edges and the zero-means-16 multiplier
    wr(10'h0F4, 32'h80A6_0000); flag(cfg_err, 1'b0, "R5"); rd(10'h0F1, 32'h11, "R4");
    wr(10'h0F4, 32'h8050_0000); flag(cfg_err, 1'b0, "R5");
    wr(10'h0F4, 32'h8061_0000); flag(cfg_err, 1'b1, "R5");
    wr(10'h0F4, 32'h8065_0000); flag(cfg_err, 1'b1, "R5");
    wr(10'h0F4, 32'h8006_0000); flag(cfg_err, 1'b0, "R5");
    wr(10'h0F4, 32'h0061_0000); flag(cfg_err, 1'b0, "R5"); flag(pll_sel, 1'b0, "R3");
    rd(10'h0F1, 32'h11, "R4");
    wr(10'h0F4, 32'h4000_0000); rd(10'h0F1, 32'h10, "R4");
    wr(10'h0F4, 32'h0000_0000); rd(10'h0F1, 32'h10, "R4");
    wr(10'h0F4, 32'h80A5_52BE); flag(pll_sel, 1'b1, "R3"); rd(10'h0F1, 32'h11, "R4");
    // R6 R7 divider patterns
    wr(10'h0F0, 32'h0000_0000); run(60);
    wr(10'h0F0, 32'h0021_1030); run(400);
    wr(10'h0F0, 32'h0020_2210); run(400);
    // R8 UART divisors, including zero meaning 128
    wr(10'h0F5, 32'h0000_0000); run(600);
    wr(10'h0F5, 32'h0000_0102); run(60);
    wr(10'h0F5, 32'h0000_7F01); run(300);
    // R9 restart mid-period with unchanged values, and back-to-back reconfiguration
    run(7);
    wr(10'h0F0, 32'h0020_2210); run(100);
    wr(10'h0F5, 32'h0000_0305); wr(10'h0F0, 32'h0000_3300); run(300);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog run incomplete actual timeout expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule